// File: doc/BRIEF.md
# Dual 8-bit Parallel Port with Bit-7 Edge Interrupt

This block provides two 8-bit general-purpose I/O ports behind a small register bus. Each port holds an output data register and a per-bit direction mask. Each direction bit that is 1 makes that pin an output and drives its output-enable. A read of a port's data offset returns a merged view: driven bits come from the output register, and undriven bits come from the pins.

Bit 7 of port A's merged value is watched every clock by a transition detector. A polarity selects a rising or a falling transition. A matching transition sets a sticky edge flag. The flag shows in a flag register that also carries a timer flag supplied from outside the block. Reading that register clears the edge flag but not the timer flag. The interrupt output is asserted when the timer flag is set and its enable is on, or when the edge flag is set and the edge enable is on.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, both direction masks and both output registers are 0x00, edge detection is disabled with falling polarity, and the edge flag is clear. With the timer inputs low, a flag-register read returns 0x00 and `irq` is 0.
- R2: A write to offset 0 or 2 (`bus_addr[2:0]`) loads the port A or port B output register. A write to offset 1 or 3 loads the port A or port B direction mask, where 1 means output. `pa_out`/`pb_out` and `pa_oe`/`pb_oe` show these registers. Address bits 4 and 3 do not affect these offsets.
- R3: A read of offset 0 or 2 returns, bit by bit, the output register bit where the direction bit is 1 and the pin input where it is 0.
- R4: A read of offset 1 or 3 returns the stored direction mask.
- R5: A write to offsets 4 to 7 with `bus_addr[4]`=0 sets the edge enable from `bus_addr[1]` and the polarity from `bus_addr[0]` (1 = rising, 0 = falling). The same write with `bus_addr[4]`=1 belongs to the timer and leaves the edge configuration unchanged.
- R6: A transition of port A's merged bit 7 in the selected direction sets the edge flag one clock later. This holds whether the transition comes from the pin or from the output register, and whether or not the edge enable is on. A transition in the other direction sets nothing.
- R7: A read of offset 5 or 7 returns `timer_flag` in bit 7, the edge flag in bit 6, and 0 in bits 5..0. The read clears the edge flag. A transition detected in the same clock as the read wins, and the flag stays set.
- R8: `irq` = (`timer_flag` AND `timer_irq_en`) OR (edge flag AND edge enable).
- R9: Reads of offsets 4 and 6 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per clock while high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pa_in | input | 8 | Port A pin inputs |
| pb_in | input | 8 | Port B pin inputs |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B per-bit output enable |
| timer_flag | input | 1 | Timer expiry flag from the timer |
| timer_irq_en | input | 1 | Timer interrupt enable from the timer |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that pin inputs, timer inputs and bus fields are synchronous to `clk`. They also assume these inputs change only between rising edges, so the bit-7 sample and the clear-on-read both see one settled value per clock. The bench drives every input on the falling edge and samples read data shortly after it. An access therefore covers exactly one rising edge. Edges are made by changing `pa_in[7]` or the output register only after the detector has been primed by at least one clock out of reset.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pa_in,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic          timer_flag,
  input  logic          timer_irq_en,
  output logic          irq
);

  localparam int WATCH = DW - 1;
  localparam int EFLAG = DW - 2;

  logic [DW-1:0] pa_eff, pb_eff, flag_word;
  logic [2:0]    off;
  logic          wr_go, rd_go, cfg_wr, flag_rd;
  logic          edge_en, edge_rise, edge_flag;
  logic          prev7, primed, hit;

  assign off     = bus_addr[2:0];
  assign wr_go   = bus_sel & bus_wr;
  assign rd_go   = bus_sel & ~bus_wr;
  assign cfg_wr  = wr_go & off[2] & ~bus_addr[4];
  assign flag_rd = rd_go & off[2] & off[0];

  assign pa_eff = (pa_in & ~pa_oe) | (pa_out & pa_oe);
  assign pb_eff = (pb_in & ~pb_oe) | (pb_out & pb_oe);

  always_comb begin
    flag_word        = '0;
    flag_word[WATCH] = timer_flag;
    flag_word[EFLAG] = edge_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_out <= '0;
      pa_oe  <= '0;
      pb_out <= '0;
      pb_oe  <= '0;
    end else if (wr_go) begin
      case (off)
        3'd0: pa_out <= bus_wdata;
        3'd1: pa_oe  <= bus_wdata;
        3'd2: pb_out <= bus_wdata;
        3'd3: pb_oe  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (off)
      3'd0:       bus_rdata = pa_eff;
      3'd1:       bus_rdata = pa_oe;
      3'd2:       bus_rdata = pb_eff;
      3'd3:       bus_rdata = pb_oe;
      3'd5, 3'd7: bus_rdata = flag_word;
      default:    bus_rdata = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_en   <= 1'b0;
      edge_rise <= 1'b0;
    end else if (cfg_wr) begin
      edge_en   <= bus_addr[1];
      edge_rise <= bus_addr[0];
    end
  end

  assign hit = primed & (edge_rise ? (pa_eff[WATCH] & ~prev7)
                                   : (~pa_eff[WATCH] & prev7));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev7     <= 1'b0;
      primed    <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      prev7  <= pa_eff[WATCH];
      primed <= 1'b1;
      if (hit)          edge_flag <= 1'b1;
      else if (flag_rd) edge_flag <= 1'b0;
    end
  end

  assign irq = (timer_flag & timer_irq_en) | (edge_flag & edge_en);

  // R2
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[2:0] == 3'd1) |=> pa_oe == $past(bus_wdata));

  // R5
  a_r5_timer_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[4]) |=> ($stable(edge_en) && $stable(edge_rise)));

  // R6
  a_r6_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> edge_flag);

  // R6
  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_flag && !hit) |=> !edge_flag);

  // R7
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !hit) |=> !edge_flag);

  // R8
  a_r8_edge_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_flag && edge_en) |-> irq);

endmodule

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pa_in = '0, pb_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
  logic       timer_flag = 1'b0, timer_irq_en = 1'b0, irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pb_in(pb_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe), .timer_flag(timer_flag),
    .timer_irq_en(timer_irq_en), .irq(irq));

  // {is_write, addr, wdata, pa_in, pb_in, expected_read}
  localparam int NV = 14;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 5'h01, 8'hF0, 8'h00, 8'h00, 8'h00},  // R2 PA dir
    {1'b1, 5'h00, 8'hA5, 8'h00, 8'h00, 8'h00},  // R2 PA out
    {1'b0, 5'h00, 8'h00, 8'h3C, 8'h00, 8'hAC},  // R3 PA mix
    {1'b0, 5'h01, 8'h00, 8'h3C, 8'h00, 8'hF0},  // R4 PA dir
    {1'b1, 5'h03, 8'h0F, 8'h00, 8'h00, 8'h00},  // R2 PB dir
    {1'b1, 5'h02, 8'h5A, 8'h00, 8'h00, 8'h00},  // R2 PB out
    {1'b0, 5'h02, 8'h00, 8'h00, 8'hC3, 8'hCA},  // R3 PB mix
    {1'b0, 5'h03, 8'h00, 8'h00, 8'hFF, 8'h0F},  // R4 PB dir
    {1'b0, 5'h04, 8'h00, 8'h00, 8'h00, 8'hFF},  // R9
    {1'b0, 5'h06, 8'h00, 8'h00, 8'h00, 8'hFF},  // R9
    {1'b1, 5'h18, 8'h11, 8'h00, 8'h00, 8'h00},  // R2 upper bits ignored
    {1'b0, 5'h00, 8'h00, 8'h00, 8'h00, 8'h10},  // R3
    {1'b0, 5'h08, 8'h00, 8'h0F, 8'h00, 8'h1F},  // R3 alias
    {1'b0, 5'h1B, 8'h00, 8'h00, 8'h00, 8'h0F}   // R4 alias
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_pin7(input logic v);
    @(negedge clk);
    pa_in[7] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check(pa_oe, 8'h00, "R1 pa_oe");
    check(pb_oe, 8'h00, "R1 pb_oe");
    check(pa_out, 8'h00, "R1 pa_out");
    check(pb_out, 8'h00, "R1 pb_out");
    check({7'd0, irq}, 8'h00, "R1 irq");
    do_rd(5'h05, got); check(got, 8'h00, "R1 flags");

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      @(negedge clk);
      pa_in = v[23:16]; pb_in = v[15:8];
      if (v[37]) do_wr(v[36:32], v[31:24]);
      else begin
        do_rd(v[36:32], got);
        check(got, v[7:0], $sformatf("R3/R4/R9 vector %0d", i));
      end
    end
    check(pa_oe, 8'hF0, "R2 pa_oe pin");
    check(pb_out, 8'h5A, "R2 pb_out pin");

    do_reset();
    pa_in = 8'h00;
    timer_flag = 1'b1;
    do_rd(5'h07, got); check(got, 8'h80, "R7 timer bit layout");
    timer_irq_en = 1'b1; #1;
    check({7'd0, irq}, 8'h01, "R8 timer irq");
    timer_irq_en = 1'b0; timer_flag = 1'b0; #1;
    check({7'd0, irq}, 8'h00, "R8 timer irq off");

    set_pin7(1'b1);
    set_pin7(1'b0);
    check({7'd0, irq}, 8'h00, "R8 edge disabled no irq");
    do_rd(5'h05, got); check(got, 8'h40, "R6 falling sets flag");
    do_rd(5'h05, got); check(got, 8'h00, "R7 read cleared flag");

    do_wr(5'h07, 8'h00);
    set_pin7(1'b1);
    check({7'd0, irq}, 8'h01, "R5 R8 rising enabled irq");
    do_rd(5'h05, got); check(got, 8'h40, "R6 rising sets flag");
    check({7'd0, irq}, 8'h00, "R7 irq drops after read");
    set_pin7(1'b0);
    do_rd(5'h05, got); check(got, 8'h00, "R6 opposite edge ignored");

    do_wr(5'h01, 8'h80);
    do_wr(5'h00, 8'h80);
    @(negedge clk);
    check({7'd0, irq}, 8'h01, "R6 output-driven edge irq");
    do_rd(5'h05, got); check(got, 8'h40, "R6 output-driven edge flag");

    do_wr(5'h14, 8'h00);
    do_wr(5'h00, 8'h00);
    do_rd(5'h05, got); check(got, 8'h00, "R5 timer write kept rising");
    do_wr(5'h00, 8'h80);
    @(negedge clk);
    check({7'd0, irq}, 8'h01, "R5 timer write kept enable");
    do_rd(5'h05, got);

    do_wr(5'h00, 8'h00);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h05;
    pa_out[7] = 1'b0;
    #1 got = bus_rdata;
    check(got, 8'h00, "R7 collision read value");
    @(negedge clk);
    bus_sel = 1'b0;
    do_wr(5'h00, 8'h80);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h05;
    @(negedge clk);
    bus_sel = 1'b0;
    do_wr(5'h00, 8'h00);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h05;
    @(negedge clk);
    bus_sel = 1'b0;
    do_rd(5'h05, got); check(got, 8'h00, "R7 flag clear before collision");
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 8'h80;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h05;
    #1 got = bus_rdata;
    check(got, 8'h00, "R7 read in detect cycle sees old flag");
    @(negedge clk);
    bus_sel = 1'b0;
    do_rd(5'h05, got); check(got, 8'h40, "R7 set wins over clear");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule